// File: doc/BRIEF.md
# Five-Level Cell Redundant Switching-State Selector

This block drives the six gates of a five-level cell made of two stacked capacitors and three complementary switch pairs. Once per control period, a period strobe tells it to take the requested output level (-2 to +2), the direction of the line current and the two sampled capacitor voltages. From these it latches one switching vector and drives all six gates from that vector until the next strobe.

Levels +2 and -2 can each be made in only one way. Levels +1, 0 and -1 each have two switching vectors. For +1 and -1, the selector picks the vector whose effect on the capacitors, given the current direction, pulls the two voltages back toward each other. When the voltage mismatch is within a programmable deadband, it keeps the option it used last time, so that it does not toggle needlessly. Level 0 has no effect on either capacitor, so it always reuses the remembered option. A request outside the legal range is treated as level 0 and sets a sticky error flag.

Top module: `cell_state_selector`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `gate_o` is 6'b101010 (the level-0 vector with Q1=0, Q4=1, Q5=0) and `err_o` is 0. The remembered redundant option is option A.
- R2: The gates are always in complementary pairs. `gate_o[0]`=Q1 and `gate_o[1]`=Q2=~Q1. `gate_o[3]`=Q4 and `gate_o[2]`=Q3=~Q4. `gate_o[4]`=Q5 and `gate_o[5]`=Q6=~Q5.
- R3: `gate_o` and `err_o` change only in the cycle after a clock edge at which `period_stb` is high. Inputs that change between strobes have no effect on the outputs.
- R4: `level_req` is a 3-bit two's-complement value. Level +2 (3'b010) gives (Q1,Q4,Q5)=(1,1,1). Level -2 (3'b110) gives (0,0,0).
- R5: Let d = vc1 - vc2. The current is positive when `cur_pos`=1. Level +1 has option A=(1,1,0) and option B=(0,1,1). Level -1 (3'b111) has option A=(1,0,0) and option B=(0,0,1). When |d| > `deadband`, the selector picks A if (d > 0) equals `cur_pos`, and B otherwise. That choice becomes the remembered option.
- R6: For level +1 or -1 with |d| <= `deadband`, the selector uses the remembered option, and the remembered option does not change.
- R7: Level 0 gives A=(0,1,0) or B=(1,0,1), following the remembered option, and it does not change the remembered option. Levels +2 and -2 also leave the remembered option unchanged.
- R8: A strobed request of 3'b011 or 3'b100 is treated as level 0 and sets `err_o`. Once set, `err_o` stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| period_stb | input | 1 | One-cycle strobe that starts a control period |
| level_req | input | 3 | Requested level, two's complement, legal range -2..+2 |
| cur_pos | input | 1 | Line current direction: 1 = zero or positive |
| vc1 | input | VW | Sampled voltage of capacitor 1 |
| vc2 | input | VW | Sampled voltage of capacitor 2 |
| deadband | input | VW | Mismatch below which the previous option is kept |
| gate_o | output | 6 | Gate drives Q1..Q6, bit i = Q(i+1) |
| err_o | output | 1 | Sticky out-of-range request flag |

## Verification
The assertions assume that `period_stb` and the data inputs are settled at each rising edge, and that the capacitor samples and deadband are unsigned values of the same width. The bench meets this by changing every input only on falling edges. It keeps voltages in a narrow window around a common value, so that inside-deadband and outside-deadband mismatches of both signs both occur. It mixes a small share of the two illegal level codes into the random requests, so that the sticky flag is exercised without hiding the balancing choice.

// File: rtl/cell_sel_pkg.sv
package cell_sel_pkg;

    localparam int NPAIR = 3;
    localparam int NGATE = 2 * NPAIR;

    typedef enum logic [2:0] {
        LV_N2 = 3'd0,
        LV_N1 = 3'd1,
        LV_Z  = 3'd2,
        LV_P1 = 3'd3,
        LV_P2 = 3'd4
    } level_e;

    typedef struct packed {
        logic q5;
        logic q4;
        logic q1;
    } sw_vec_t;

    localparam sw_vec_t RESET_VEC = '{q5: 1'b0, q4: 1'b1, q1: 1'b0};

    function automatic logic is_paired(input level_e lv);
        return (lv == LV_P1) || (lv == LV_N1);
    endfunction

    function automatic sw_vec_t map_vec(input level_e lv, input logic alt);
        sw_vec_t v;
        unique case (lv)
            LV_P2:   v = '{q5: 1'b1, q4: 1'b1, q1: 1'b1};
            LV_N2:   v = '{q5: 1'b0, q4: 1'b0, q1: 1'b0};
            LV_P1:   v = alt ? '{q5: 1'b1, q4: 1'b1, q1: 1'b0}
                             : '{q5: 1'b0, q4: 1'b1, q1: 1'b1};
            LV_N1:   v = alt ? '{q5: 1'b1, q4: 1'b0, q1: 1'b0}
                             : '{q5: 1'b0, q4: 1'b0, q1: 1'b1};
            default: v = alt ? '{q5: 1'b1, q4: 1'b0, q1: 1'b1}
                             : '{q5: 1'b0, q4: 1'b1, q1: 1'b0};
        endcase
        return v;
    endfunction

endpackage

// File: rtl/cell_level_guard.sv
module cell_level_guard
    import cell_sel_pkg::*;
(
    input  logic [2:0] req,
    output level_e     lvl,
    output logic       bad
);
    always_comb begin
        bad = 1'b0;
        unique case (req)
            3'b110:  lvl = LV_N2;
            3'b111:  lvl = LV_N1;
            3'b000:  lvl = LV_Z;
            3'b001:  lvl = LV_P1;
            3'b010:  lvl = LV_P2;
            default: begin
                lvl = LV_Z;
                bad = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/cell_balance_chooser.sv
module cell_balance_chooser
    import cell_sel_pkg::*;
#(
    parameter int VW = 12
) (
    input  level_e          lvl,
    input  logic            cur_pos,
    input  logic [VW-1:0]   vc1,
    input  logic [VW-1:0]   vc2,
    input  logic [VW-1:0]   deadband,
    input  logic            pick_q,
    output logic            alt,
    output logic            pick_d
);
    logic          c1_high;
    logic [VW-1:0] mag;
    logic          outside;
    logic          fresh;

    always_comb begin
        c1_high = vc1 > vc2;
        mag     = c1_high ? (vc1 - vc2) : (vc2 - vc1);
        outside = mag > deadband;
        // option A lowers vc1-vc2 for positive current, raises it for negative
        fresh   = (c1_high != cur_pos);
        if (is_paired(lvl) && outside) begin
            alt = fresh;
        end else begin
            alt = pick_q;
        end
        pick_d = is_paired(lvl) ? alt : pick_q;
    end
endmodule

// File: rtl/cell_gate_former.sv
module cell_gate_former
    import cell_sel_pkg::*;
(
    input  sw_vec_t           vec,
    output logic [NGATE-1:0]  gate
);
    logic [NPAIR-1:0] prim;
    assign prim = {vec.q5, vec.q4, vec.q1};

    for (genvar k = 0; k < NPAIR; k++) begin : g_pair
        if (k == 1) begin : g_swap
            assign gate[2*k+1] = prim[k];
            assign gate[2*k]   = ~prim[k];
        end else begin : g_norm
            assign gate[2*k]   = prim[k];
            assign gate[2*k+1] = ~prim[k];
        end
    end
endmodule

// File: rtl/cell_state_selector.sv
module cell_state_selector
    import cell_sel_pkg::*;
#(
    parameter int VW = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          period_stb,
    input  logic [2:0]    level_req,
    input  logic          cur_pos,
    input  logic [VW-1:0] vc1,
    input  logic [VW-1:0] vc2,
    input  logic [VW-1:0] deadband,
    output logic [5:0]    gate_o,
    output logic          err_o
);
    level_e  lvl;
    logic    bad;
    logic    alt;
    logic    pick_d;
    logic    pick_q;
    sw_vec_t vec_d;
    sw_vec_t vec_q;
    logic    err_q;

    cell_level_guard guard_i (
        .req (level_req),
        .lvl (lvl),
        .bad (bad)
    );

    cell_balance_chooser #(.VW(VW)) chooser_i (
        .lvl      (lvl),
        .cur_pos  (cur_pos),
        .vc1      (vc1),
        .vc2      (vc2),
        .deadband (deadband),
        .pick_q   (pick_q),
        .alt      (alt),
        .pick_d   (pick_d)
    );

    assign vec_d = map_vec(lvl, alt);

    always_ff @(posedge clk) begin
        if (rst) begin
            vec_q  <= RESET_VEC;
            pick_q <= 1'b0;
            err_q  <= 1'b0;
        end else if (period_stb) begin
            vec_q  <= vec_d;
            pick_q <= pick_d;
            err_q  <= err_q | bad;
        end
    end

    cell_gate_former former_i (
        .vec  (vec_q),
        .gate (gate_o)
    );

    assign err_o = err_q;
endmodule

// File: rtl/cell_state_selector_chk.sv
module cell_state_selector_chk #(
    parameter int VW = 12
) (
    input logic          clk,
    input logic          rst,
    input logic          period_stb,
    input logic [2:0]    level_req,
    input logic          cur_pos,
    input logic [VW-1:0] vc1,
    input logic [VW-1:0] vc2,
    input logic [VW-1:0] deadband,
    input logic [5:0]    gate_o,
    input logic          err_o
);
    a_r2_complement: assert property (@(posedge clk) disable iff (rst)
        (gate_o[1] == ~gate_o[0]) && (gate_o[2] == ~gate_o[3]) && (gate_o[5] == ~gate_o[4]));

    a_r3_hold: assert property (@(posedge clk) disable iff (rst)
        !period_stb |=> ($stable(gate_o) && $stable(err_o)));

    a_r4_plus2: assert property (@(posedge clk) disable iff (rst)
        (period_stb && level_req == 3'b010) |=> (gate_o == 6'b011001));

    a_r4_minus2: assert property (@(posedge clk) disable iff (rst)
        (period_stb && level_req == 3'b110) |=> (gate_o == 6'b100110));

    a_r5_plus1_pos: assert property (@(posedge clk) disable iff (rst)
        (period_stb && level_req == 3'b001 && cur_pos &&
         ({1'b0, vc1} > ({1'b0, vc2} + {1'b0, deadband})))
        |=> (gate_o == 6'b101001));

    a_r8_sticky: assert property (@(posedge clk) disable iff (rst)
        err_o |=> err_o);

    a_r8_set: assert property (@(posedge clk) disable iff (rst)
        (period_stb && (level_req == 3'b011 || level_req == 3'b100)) |=> err_o);
endmodule

bind cell_state_selector cell_state_selector_chk #(.VW(VW)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .period_stb (period_stb),
    .level_req  (level_req),
    .cur_pos    (cur_pos),
    .vc1        (vc1),
    .vc2        (vc2),
    .deadband   (deadband),
    .gate_o     (gate_o),
    .err_o      (err_o)
);

// File: tb/cell_state_selector_tb_top.sv
module cell_state_selector_tb_top;
    localparam int VW = 12;
    localparam int CLK_PERIOD = 10;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          period_stb = 1'b0;
    logic [2:0]    level_req = 3'b000;
    logic          cur_pos = 1'b1;
    logic [VW-1:0] vc1 = '0;
    logic [VW-1:0] vc2 = '0;
    logic [VW-1:0] deadband = '0;
    logic [5:0]    gate_o;
    logic          err_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    bit       m_pick = 1'b0;
    bit       m_err = 1'b0;
    bit [5:0] m_gate = 6'b101010;

    always #(CLK_PERIOD/2) clk = ~clk;

    cell_state_selector #(.VW(VW)) dut_i (
        .clk(clk), .rst(rst), .period_stb(period_stb), .level_req(level_req),
        .cur_pos(cur_pos), .vc1(vc1), .vc2(vc2), .deadband(deadband),
        .gate_o(gate_o), .err_o(err_o)
    );

    function automatic bit [5:0] gates_of(bit q1, bit q4, bit q5);
        return {~q5, q5, q4, ~q4, ~q1, q1};
    endfunction

    // expected-value model built from R4..R8
    task automatic model(input bit [2:0] lq, input bit cp, input int v1, input int v2, input int db);
        int lv;
        int d;
        lv = int'($signed(lq));
        if (lv < -2 || lv > 2) begin
            m_err = 1'b1;
            lv = 0;
        end
        d = v1 - v2;
        if ((lv == 1 || lv == -1) && ((d < 0 ? -d : d) > db))
            m_pick = !((d > 0) == cp);
        case (lv)
            2:  m_gate = gates_of(1, 1, 1);
            -2: m_gate = gates_of(0, 0, 0);
            1:  m_gate = m_pick ? gates_of(0, 1, 1) : gates_of(1, 1, 0);
            -1: m_gate = m_pick ? gates_of(0, 0, 1) : gates_of(1, 0, 0);
            default: m_gate = m_pick ? gates_of(1, 0, 1) : gates_of(0, 1, 0);
        endcase
    endtask

    task automatic check(input string req, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic apply(input string req, input bit [2:0] lq, input bit cp,
                         input int v1, input int v2, input int db);
        @(negedge clk);
        level_req = lq; cur_pos = cp;
        vc1 = VW'(v1); vc2 = VW'(v2); deadband = VW'(db);
        period_stb = 1'b1;
        @(negedge clk);
        period_stb = 1'b0;
        model(lq, cp, v1, v2, db);
        check(req, int'(gate_o), int'(m_gate));
        check({req, " err"}, int'(err_o), int'(m_err));
        check("R2 pairs", int'(gate_o[1] ^ gate_o[0]) + int'(gate_o[2] ^ gate_o[3]) +
              int'(gate_o[5] ^ gate_o[4]), 3);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog: got hang expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        check("R1 reset gates", int'(gate_o), 6'b101010);
        check("R1 reset err", int'(err_o), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 after reset gates", int'(gate_o), 6'b101010);

        apply("R4 plus2", 3'b010, 1, 2000, 2000, 4);
        apply("R4 minus2", 3'b110, 0, 2000, 2000, 4);
        // R5: vc1 high, positive current -> option A at +1
        apply("R5 p1 A", 3'b001, 1, 2050, 2000, 4);
        // R5: vc1 high, negative current -> option B at -1
        apply("R5 n1 B", 3'b111, 0, 2050, 2000, 4);
        // R7: level 0 follows remembered option B
        apply("R7 zero B", 3'b000, 1, 2000, 2100, 4);
        // R6: within deadband keeps option B
        apply("R6 p1 hold", 3'b001, 1, 2003, 2000, 4);
        // R5: vc2 high, positive current -> option B
        apply("R5 p1 B", 3'b001, 1, 2000, 2030, 4);
        apply("R5 n1 A", 3'b111, 1, 2040, 2000, 4);
        apply("R7 zero A", 3'b000, 0, 2040, 2000, 4);

        // R3: inputs move without strobe, outputs hold
        @(negedge clk);
        level_req = 3'b010; cur_pos = 1'b0; vc1 = 12'd100; vc2 = 12'd900;
        repeat (3) @(negedge clk);
        check("R3 hold gates", int'(gate_o), int'(m_gate));
        check("R3 hold err", int'(err_o), 0);

        apply("R8 plus3", 3'b011, 1, 2000, 2000, 4);
        apply("R8 minus4", 3'b100, 1, 2000, 2000, 4);
        apply("R8 sticky", 3'b010, 1, 2000, 2000, 4);

        for (int i = 0; i < 400; i++) begin
            bit [2:0] lq;
            int r;
            r = $urandom % 20;
            if (r == 0) lq = 3'b011;
            else if (r == 1) lq = 3'b100;
            else begin
                int pick5;
                pick5 = $urandom % 5;
                lq = 3'(pick5 - 2);
            end
            apply("R5 R6 R7 random", lq, 1'($urandom),
                  2000 + int'($urandom % 64), 2000 + int'($urandom % 64),
                  int'($urandom % 16));
        end

        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        m_pick = 1'b0; m_err = 1'b0; m_gate = 6'b101010;
        check("R1 reclear err", int'(err_o), 0);
        check("R1 reclear gates", int'(gate_o), 6'b101010);
        apply("R1 pick reset A", 3'b000, 1, 2000, 2000, 4);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule